// File: doc/BRIEF.md
# I2C Status and Interrupt Flag Unit

This block holds the 16-bit status word of an I2C controller peripheral together with its interrupt flags, its interrupt mask and the CPU-side data location. It watches the SDA and SCL lines through two-flop synchronizers. When SCL is high, a falling SDA edge is a START (or repeated START) and a rising SDA edge is a STOP. These two conditions keep a bus-busy bit up to date. Single-cycle strobes arrive from a separate shift engine: a byte received, a NACK seen, arbitration lost, and an address byte captured during the address phase. The unit turns these strobes into sticky flags. The flags follow three rules. Some are read/write, so software can set them to raise an interrupt on purpose. Some are set only by hardware, and software can only clear them. The overrun flag is cleared by a read of the data location.

A simple register bus (select, write, 3-bit address, 16-bit data) reaches five locations:

| Address | Contents |
|---------|----------|
| 0 | Status |
| 1 | Data: a write fills the transmit byte, a read returns the last received byte |
| 2 | Control: bit 0 enable, bit 1 master mode, bit 2 general-call recognition |
| 3 | Interrupt enable, one bit per status bit |
| 4 | Own slave address, 7 bits |

Reads are combinational. All other addresses read as 0. The interrupt output is the OR of every flag ANDed with its enable bit.

Top module: `i2c_flag_unit`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, the status word, `irq`, `master_mode`, `tx_byte` and `tx_addr` are all 0.
- R2: When enabled, a START sets status bit 15 and a STOP clears it, with a delay of three clocks after the line change. Bit 15 reads 0 whenever control bit 0 is 0.
- R3: Status bit 14 is 1 exactly when the unit is enabled and either `ctl_active` is high, or the bus is busy while control bit 1 (master) is 0.
- R4: Status bits 13:12 and 4:0 always read 0.
- R5: Status bit 11 is set by a STOP. A status write loads it with the written bit, so software can both clear it and set it.
- R6: Status bit 10 shows the SCL level two clocks after the pin changes, and status writes have no effect on it.
- R7: Status bit 9 is set when a byte is received while the previously received byte has not been read. A read of address 1 clears it. Writing 0 to it has no effect, and writing 1 sets it.
- R8: Status bit 8 is set when the captured address is 0 and control bit 2 is 1. A captured address of 0 leaves it unchanged when control bit 2 is 0. Software writes load it.
- R9: Status bits 7 (NACK) and 6 (arbitration lost) are set only by their strobes. Writing 0 clears them and writing 1 leaves them unchanged. An arbitration-lost strobe also clears control bit 1 and `master_mode`.
- R10: Status bit 5 is set when the captured 7-bit address equals the slave-address register. Software writes load it.
- R11: `irq` is 1 exactly when some flag among status bits 11 and 9:5 is 1 and its interrupt-enable bit is 1.
- R12: A write to address 1 updates `tx_byte`, and `tx_addr` shows that byte's bits 6:0. A read of address 1 returns the last received byte, not the transmit byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| ctl_active | input | 1 | Engine is taking part in a transfer |
| rx_strobe | input | 1 | A received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| nack_strobe | input | 1 | Transmitter saw a NACK |
| arb_lost_strobe | input | 1 | Master lost arbitration |
| addr_strobe | input | 1 | An address-phase address is on `addr_rx` |
| addr_rx | input | 7 | Captured 7-bit address |
| cpu_sel | input | 1 | Register access this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for `cpu_addr` |
| tx_byte | output | 8 | Byte queued for transmit |
| tx_addr | output | 7 | Transmit byte bits 6:0, used as the address when one is sent |
| master_mode | output | 1 | Control bit 1 |
| irq | output | 1 | Masked interrupt request |

## Verification
The in-line assertions check on every cycle:
- that disabling the unit or seeing a STOP leaves bus-busy low, and that an enabled START raises it;
- that the hardware-only flags rise only after their strobes;
- that a data read clears the overrun flag;
- that arbitration loss drops master mode;
- that the reserved bits stay low and that the transmit byte holds between writes.

Only the bench scenarios, checked against a cycle-accurate reference model, can show the rest:
- the synchronizer latency on SCL and SDA;
- the overrun sequence of two receives before one read;
- the priority when a read and a receive land in the same cycle;
- address and general-call matching against programmed values;
- the write-0 and write-1 semantics that differ from flag to flag.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
  localparam int STAT_W = 16;
  localparam int BYTE_W = 8;
  localparam int ADR7_W = 7;
  localparam int CPU_AW = 3;
  localparam int CTRL_W = 3;

  localparam int B_BUSBUSY = 15;
  localparam int B_CTLBUSY = 14;
  localparam int B_STOP    = 11;
  localparam int B_SCL     = 10;
  localparam int B_OVR     = 9;
  localparam int B_GCALL   = 8;
  localparam int B_NACK    = 7;
  localparam int B_ARB     = 6;
  localparam int B_AMATCH  = 5;

  localparam int C_EN   = 0;
  localparam int C_MST  = 1;
  localparam int C_GCEN = 2;

  localparam logic [CPU_AW-1:0] A_STAT = 3'd0;
  localparam logic [CPU_AW-1:0] A_DATA = 3'd1;
  localparam logic [CPU_AW-1:0] A_CTRL = 3'd2;
  localparam logic [CPU_AW-1:0] A_IEN  = 3'd3;
  localparam logic [CPU_AW-1:0] A_SLA  = 3'd4;

  typedef enum logic [1:0] {
    FK_NONE,
    FK_RW,
    FK_HW,
    FK_W1S
  } flag_kind_e;

  function automatic flag_kind_e kind_of(input int idx);
    case (idx)
      B_STOP, B_GCALL, B_AMATCH: kind_of = FK_RW;
      B_NACK, B_ARB:             kind_of = FK_HW;
      B_OVR:                     kind_of = FK_W1S;
      default:                   kind_of = FK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/flag_cell.sv
module flag_cell
  import i2c_flag_pkg::*;
#(
  parameter flag_kind_e KIND = FK_RW
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic rd_clr,
  input  logic wr_en,
  input  logic wr_bit,
  output logic q
);
  logic q_nxt;
  logic upd;

  always_comb begin
    q_nxt = q;
    if (KIND == FK_RW) begin
      if (hw_set)     q_nxt = 1'b1;
      else if (wr_en) q_nxt = wr_bit;
    end else if (KIND == FK_HW) begin
      if (hw_set)                q_nxt = 1'b1;
      else if (wr_en && !wr_bit) q_nxt = 1'b0;
    end else if (KIND == FK_W1S) begin
      if (hw_set)               q_nxt = 1'b1;
      else if (rd_clr)          q_nxt = 1'b0;
      else if (wr_en && wr_bit) q_nxt = 1'b1;
    end else begin
      q_nxt = 1'b0;
    end
  end

  assign upd = hw_set | rd_clr | wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (upd) q <= q_nxt;
  end

  generate
    if (KIND == FK_HW) begin : g_hw_chk
      // R9: a hardware-only flag rises only after its strobe
      a_r9_hw_only_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(hw_set));
    end
    if (KIND == FK_W1S) begin : g_w1s_chk
      // R7: a data read with no receive in the same cycle clears the flag
      a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !hw_set) |=> !q);
    end
  endgenerate
endmodule

// File: rtl/flag_bank.sv
module flag_bank
  import i2c_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] hw_set,
  input  logic              rd_clr,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] flags
);
  logic unused_inputs;
  assign unused_inputs = ^{hw_set, wr_data};

  generate
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      if (kind_of(i) == FK_NONE) begin : g_none
        assign flags[i] = 1'b0;
      end else begin : g_cell
        flag_cell #(.KIND(kind_of(i))) u_cell (
          .clk    (clk),
          .rst_n  (rst_n),
          .hw_set (hw_set[i]),
          .rd_clr (rd_clr),
          .wr_en  (wr_en),
          .wr_bit (wr_data[i]),
          .q      (flags[i])
        );
      end
    end
  endgenerate
endmodule

// File: rtl/line_monitor.sv
module line_monitor #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_level,
  output logic start_seen,
  output logic stop_seen,
  output logic bus_busy
);
  logic [SYNC_N-1:0] scl_chain, scl_chain_nxt;
  logic [SYNC_N-1:0] sda_chain, sda_chain_nxt;
  logic scl_prev, sda_prev;
  logic scl_now, sda_now;
  logic busy_q, busy_nxt;

  assign scl_now   = scl_chain[SYNC_N-1];
  assign sda_now   = sda_chain[SYNC_N-1];
  assign scl_level = scl_now;

  always_comb begin
    scl_chain_nxt = {scl_chain[SYNC_N-2:0], scl_in};
    sda_chain_nxt = {sda_chain[SYNC_N-2:0], sda_in};
    start_seen = scl_now & scl_prev & sda_prev & ~sda_now;
    stop_seen  = scl_now & scl_prev & ~sda_prev & sda_now;
    busy_nxt = busy_q;
    if (!en)             busy_nxt = 1'b0;
    else if (stop_seen)  busy_nxt = 1'b0;
    else if (start_seen) busy_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '0;
      sda_chain <= '0;
      scl_prev  <= 1'b0;
      sda_prev  <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      scl_chain <= scl_chain_nxt;
      sda_chain <= sda_chain_nxt;
      scl_prev  <= scl_now;
      sda_prev  <= sda_now;
      busy_q    <= busy_nxt;
    end
  end

  assign bus_busy = busy_q;

  a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !bus_busy);
  a_r2_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !bus_busy);
  a_r2_start_claims: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start_seen) |=> bus_busy);
endmodule

// File: rtl/data_port.sv
module data_port
  import i2c_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_strobe,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rd_strobe,
  input  logic              wr_strobe,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rx_buf,
  output logic [BYTE_W-1:0] tx_buf,
  output logic              overrun_hit
);
  logic rx_full_q, rx_full_nxt;
  logic full_upd;

  always_comb begin
    overrun_hit = rx_strobe & rx_full_q & ~rd_strobe;
    rx_full_nxt = rx_full_q;
    if (rx_strobe)      rx_full_nxt = 1'b1;
    else if (rd_strobe) rx_full_nxt = 1'b0;
  end

  assign full_upd = rx_strobe | rd_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_full_q <= 1'b0;
    else if (full_upd) rx_full_q <= rx_full_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_buf <= '0;
    else if (rx_strobe) rx_buf <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_buf <= '0;
    else if (wr_strobe) tx_buf <= wr_data;
  end

  a_r12_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |=> $stable(tx_buf));
endmodule

// File: rtl/i2c_flag_unit.sv
module i2c_flag_unit
  import i2c_flag_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              ctl_active,
  input  logic              rx_strobe,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              nack_strobe,
  input  logic              arb_lost_strobe,
  input  logic              addr_strobe,
  input  logic [ADR7_W-1:0] addr_rx,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [STAT_W-1:0] cpu_wdata,
  output logic [STAT_W-1:0] cpu_rdata,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [ADR7_W-1:0] tx_addr,
  output logic              master_mode,
  output logic              irq
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic wr_stat, wr_data, rd_data, wr_ctrl, wr_ien, wr_sla;
  assign wr_stat = cpu_sel &  cpu_wr & (cpu_addr == A_STAT);
  assign wr_data = cpu_sel &  cpu_wr & (cpu_addr == A_DATA);
  assign rd_data = cpu_sel & ~cpu_wr & (cpu_addr == A_DATA);
  assign wr_ctrl = cpu_sel &  cpu_wr & (cpu_addr == A_CTRL);
  assign wr_ien  = cpu_sel &  cpu_wr & (cpu_addr == A_IEN);
  assign wr_sla  = cpu_sel &  cpu_wr & (cpu_addr == A_SLA);

  logic [CTRL_W-1:0] ctrl_q, ctrl_nxt;
  logic [STAT_W-1:0] ien_q;
  logic [ADR7_W-1:0] sla_q;
  logic              ctrl_upd;

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (wr_ctrl)         ctrl_nxt = cpu_wdata[CTRL_W-1:0];
    if (arb_lost_strobe) ctrl_nxt[C_MST] = 1'b0;
  end
  assign ctrl_upd = wr_ctrl | arb_lost_strobe;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    ctrl_q <= '0;
    else if (ctrl_upd) ctrl_q <= ctrl_nxt;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  ien_q <= '0;
    else if (wr_ien) ien_q <= cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  sla_q <= '0;
    else if (wr_sla) sla_q <= cpu_wdata[ADR7_W-1:0];
  end

  logic scl_level, start_seen, stop_seen, bus_busy;

  line_monitor #(.SYNC_N(SYNC_N)) u_line (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en         (ctrl_q[C_EN]),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .scl_level  (scl_level),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .bus_busy   (bus_busy)
  );

  logic [BYTE_W-1:0] rx_buf, tx_buf;
  logic              overrun_hit;

  data_port u_data (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .rx_strobe   (rx_strobe),
    .rx_data     (rx_data),
    .rd_strobe   (rd_data),
    .wr_strobe   (wr_data),
    .wr_data     (cpu_wdata[BYTE_W-1:0]),
    .rx_buf      (rx_buf),
    .tx_buf      (tx_buf),
    .overrun_hit (overrun_hit)
  );

  logic own_hit, gcall_hit;
  logic [STAT_W-1:0] hw_set, flags;

  assign own_hit   = addr_strobe & (addr_rx == sla_q);
  assign gcall_hit = addr_strobe & ctrl_q[C_GCEN] & (addr_rx == '0);

  always_comb begin
    hw_set           = '0;
    hw_set[B_STOP]   = stop_seen;
    hw_set[B_OVR]    = overrun_hit;
    hw_set[B_GCALL]  = gcall_hit;
    hw_set[B_NACK]   = nack_strobe;
    hw_set[B_ARB]    = arb_lost_strobe;
    hw_set[B_AMATCH] = own_hit;
  end

  flag_bank u_flags (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .hw_set  (hw_set),
    .rd_clr  (rd_data),
    .wr_en   (wr_stat),
    .wr_data (cpu_wdata),
    .flags   (flags)
  );

  logic              ctl_busy;
  logic [STAT_W-1:0] status_word;

  assign ctl_busy = ctrl_q[C_EN] & (ctl_active | (bus_busy & ~ctrl_q[C_MST]));

  always_comb begin
    status_word            = flags;
    status_word[B_BUSBUSY] = bus_busy;
    status_word[B_CTLBUSY] = ctl_busy;
    status_word[B_SCL]     = scl_level;
  end

  always_comb begin
    case (cpu_addr)
      A_STAT:  cpu_rdata = status_word;
      A_DATA:  cpu_rdata = {{(STAT_W-BYTE_W){1'b0}}, rx_buf};
      A_CTRL:  cpu_rdata = {{(STAT_W-CTRL_W){1'b0}}, ctrl_q};
      A_IEN:   cpu_rdata = ien_q;
      A_SLA:   cpu_rdata = {{(STAT_W-ADR7_W){1'b0}}, sla_q};
      default: cpu_rdata = '0;
    endcase
  end

  assign irq         = |(flags & ien_q);
  assign tx_byte     = tx_buf;
  assign tx_addr     = tx_buf[ADR7_W-1:0];
  assign master_mode = ctrl_q[C_MST];

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (status_word[13:12] == 2'b00) && (status_word[4:0] == 5'b00000));
  a_r9_master_drop: assert property (@(posedge clk) disable iff (!rst_int_n)
    arb_lost_strobe |=> !master_mode);
  a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ien_q == '0) |-> !irq);
endmodule

// File: tb/test_i2c_flag_unit.sv
module test_i2c_flag_unit;
  localparam int CLK_P = 10;

  logic        clk, rst_n, scl_in, sda_in, ctl_active;
  logic        rx_strobe, nack_strobe, arb_lost_strobe, addr_strobe;
  logic [7:0]  rx_data;
  logic [6:0]  addr_rx;
  logic        cpu_sel, cpu_wr;
  logic [2:0]  cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic [7:0]  tx_byte;
  logic [6:0]  tx_addr;
  logic        master_mode, irq;

  int checks = 0;
  int errors = 0;

  i2c_flag_unit i_i2c_flag_unit (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .ctl_active(ctl_active), .rx_strobe(rx_strobe), .rx_data(rx_data),
    .nack_strobe(nack_strobe), .arb_lost_strobe(arb_lost_strobe),
    .addr_strobe(addr_strobe), .addr_rx(addr_rx), .cpu_sel(cpu_sel),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .tx_byte(tx_byte), .tx_addr(tx_addr),
    .master_mode(master_mode), .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  // Reference model state
  logic        m_busy, m_rxfull;
  logic [15:0] m_flags, m_ien;
  logic [2:0]  m_ctrl;
  logic [6:0]  m_sla;
  logic [7:0]  m_rx, m_tx;
  logic        scl_h [3];
  logic        sda_h [3];
  int          rcnt;

  task automatic model_reset();
    m_busy = 0; m_rxfull = 0; m_flags = 0; m_ien = 0; m_ctrl = 0;
    m_sla = 0; m_rx = 0; m_tx = 0;
    for (int k = 0; k < 3; k++) begin scl_h[k] = 0; sda_h[k] = 0; end
  endtask

  task automatic model_step();
    logic st, sp, rd, wst, ovr_hit;
    logic [15:0] hw;
    st  = scl_h[1] && scl_h[2] && sda_h[2] && !sda_h[1];
    sp  = scl_h[1] && scl_h[2] && !sda_h[2] && sda_h[1];
    rd  = cpu_sel && !cpu_wr && cpu_addr == 3'd1;
    wst = cpu_sel && cpu_wr && cpu_addr == 3'd0;
    ovr_hit = rx_strobe && m_rxfull && !rd;
    hw = 16'h0;
    hw[11] = sp;
    hw[9]  = ovr_hit;
    hw[8]  = addr_strobe && m_ctrl[2] && addr_rx == 7'd0;
    hw[7]  = nack_strobe;
    hw[6]  = arb_lost_strobe;
    hw[5]  = addr_strobe && addr_rx == m_sla;
    foreach (hw[b]) begin
      if (b == 11 || b == 8 || b == 5) begin
        if (hw[b]) m_flags[b] = 1; else if (wst) m_flags[b] = cpu_wdata[b];
      end else if (b == 7 || b == 6) begin
        if (hw[b]) m_flags[b] = 1; else if (wst && !cpu_wdata[b]) m_flags[b] = 0;
      end else if (b == 9) begin
        if (hw[b]) m_flags[b] = 1;
        else if (rd) m_flags[b] = 0;
        else if (wst && cpu_wdata[b]) m_flags[b] = 1;
      end
    end
    if (!m_ctrl[0]) m_busy = 0;
    else if (sp) m_busy = 0;
    else if (st) m_busy = 1;
    if (rx_strobe) begin m_rx = rx_data; m_rxfull = 1; end
    else if (rd) m_rxfull = 0;
    if (cpu_sel && cpu_wr) begin
      case (cpu_addr)
        3'd1: m_tx = cpu_wdata[7:0];
        3'd2: m_ctrl = cpu_wdata[2:0];
        3'd3: m_ien = cpu_wdata;
        3'd4: m_sla = cpu_wdata[6:0];
        default: ;
      endcase
    end
    if (arb_lost_strobe) m_ctrl[1] = 0;
    scl_h[2] = scl_h[1]; scl_h[1] = scl_h[0]; scl_h[0] = scl_in;
    sda_h[2] = sda_h[1]; sda_h[1] = sda_h[0]; sda_h[0] = sda_in;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin model_reset(); rcnt = 0; end
    else if (rcnt < 2) rcnt++;
    else model_step();
  end

  function automatic logic [15:0] exp_status();
    logic [15:0] s;
    s = m_flags;
    s[15] = m_busy;
    s[14] = m_ctrl[0] && (ctl_active || (m_busy && !m_ctrl[1]));
    s[10] = scl_h[1];
    return s;
  endfunction

  function automatic string bit_tag(int b);
    case (b)
      15: return "R2";  14: return "R3";  11: return "R5";  10: return "R6";
      9:  return "R7";  8:  return "R8";  7:  return "R9";  6:  return "R9";
      5:  return "R10";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    logic [15:0] es, er;
    if (!rst_n) begin
      chk("R1", {cpu_rdata[15:0]}, 16'h0);
      chk("R1", {7'h0, irq, master_mode, tx_addr}, 16'h0);
    end else if (rcnt >= 2 || rcnt < 2) begin
      es = exp_status();
      if (cpu_addr == 3'd0) begin
        for (int b = 0; b < 16; b++) begin
          checks++;
          if (cpu_rdata[b] !== es[b]) begin
            errors++;
            $display("FAIL %s status bit %0d actual=%b expected=%b at %0t",
                     bit_tag(b), b, cpu_rdata[b], es[b], $time);
          end
        end
      end else begin
        case (cpu_addr)
          3'd1: er = {8'h0, m_rx};
          3'd2: er = {13'h0, m_ctrl};
          3'd3: er = m_ien;
          3'd4: er = {9'h0, m_sla};
          default: er = 16'h0;
        endcase
        chk("R12", cpu_rdata, er);
      end
      chk("R11", {15'h0, irq}, {15'h0, |(m_flags & m_ien)});
      chk("R9",  {15'h0, master_mode}, {15'h0, m_ctrl[1]});
      chk("R12", {tx_addr, tx_byte}, {m_tx[6:0], m_tx});
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cpu_write(logic [2:0] a, logic [15:0] d);
    @(posedge clk); #1;
    cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1;
    cpu_sel = 0; cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0;
  endtask

  task automatic cpu_read(logic [2:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    cpu_sel = 1; cpu_wr = 0; cpu_addr = a;
    #3 d = cpu_rdata;
    @(posedge clk); #1;
    cpu_sel = 0; cpu_addr = 0;
  endtask

  task automatic lines(logic c, logic d);
    @(posedge clk); #1;
    scl_in = c; sda_in = d;
    idle(4);
  endtask

  task automatic rx(logic [7:0] v);
    @(posedge clk); #1; rx_strobe = 1; rx_data = v;
    @(posedge clk); #1; rx_strobe = 0;
  endtask

  task automatic addr(logic [6:0] v);
    @(posedge clk); #1; addr_strobe = 1; addr_rx = v;
    @(posedge clk); #1; addr_strobe = 0;
  endtask

  task automatic stat_bit(string tag, int b, logic v);
    logic [15:0] r;
    cpu_read(3'd0, r);
    chk(tag, {15'h0, r[b]}, {15'h0, v});
  endtask

  initial begin
    logic [15:0] r;
    rst_n = 0; scl_in = 1; sda_in = 1; ctl_active = 0;
    rx_strobe = 0; rx_data = 0; nack_strobe = 0; arb_lost_strobe = 0;
    addr_strobe = 0; addr_rx = 0;
    cpu_sel = 0; cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    idle(6);

    // R2: START while disabled leaves bus-busy low
    lines(1, 0);
    stat_bit("R2", 15, 0);
    lines(1, 1);
    cpu_write(3'd0, 16'h0000);
    // R6: SCL level visible
    lines(0, 1);
    stat_bit("R6", 10, 0);
    cpu_write(3'd0, 16'h0400);
    stat_bit("R6", 10, 0);
    lines(1, 1);
    stat_bit("R6", 10, 1);

    cpu_write(3'd2, 16'h0001);
    cpu_write(3'd3, 16'h0BE0);
    // R2: START sets bus busy
    lines(1, 0);
    stat_bit("R2", 15, 1);
    stat_bit("R3", 14, 1);
    lines(0, 0);
    lines(0, 1);
    lines(0, 0);
    cpu_write(3'd2, 16'h0003);
    stat_bit("R3", 14, 0);
    ctl_active = 1;
    idle(1);
    stat_bit("R3", 14, 1);
    ctl_active = 0;
    // STOP
    lines(1, 0);
    lines(1, 1);
    stat_bit("R2", 15, 0);
    stat_bit("R5", 11, 1);
    chk("R11", {15'h0, irq}, 16'h1);
    cpu_write(3'd0, 16'h0000);
    stat_bit("R5", 11, 0);
    cpu_write(3'd0, 16'h0800);
    stat_bit("R5", 11, 1);
    cpu_write(3'd0, 16'h0000);

    // R7 / R12: receive path
    rx(8'h5A);
    cpu_read(3'd1, r);
    chk("R12", r, 16'h005A);
    rx(8'h11);
    rx(8'h22);
    stat_bit("R7", 9, 1);
    cpu_write(3'd0, 16'h0000);
    stat_bit("R7", 9, 1);
    cpu_read(3'd1, r);
    chk("R7", r, 16'h0022);
    stat_bit("R7", 9, 0);
    cpu_write(3'd0, 16'h0200);
    stat_bit("R7", 9, 1);
    cpu_read(3'd1, r);
    stat_bit("R7", 9, 0);
    // read and receive in the same cycle: no overrun
    rx(8'h33);
    @(posedge clk); #1;
    cpu_sel = 1; cpu_wr = 0; cpu_addr = 3'd1; rx_strobe = 1; rx_data = 8'h44;
    @(posedge clk); #1;
    cpu_sel = 0; cpu_addr = 0; rx_strobe = 0;
    stat_bit("R7", 9, 0);
    cpu_read(3'd1, r);

    // R10 / R8: address matching
    cpu_write(3'd4, 16'h002A);
    addr(7'h2B);
    stat_bit("R10", 5, 0);
    addr(7'h2A);
    stat_bit("R10", 5, 1);
    addr(7'h00);
    stat_bit("R8", 8, 0);
    cpu_write(3'd2, 16'h0005);
    addr(7'h00);
    stat_bit("R8", 8, 1);
    cpu_write(3'd0, 16'h0000);

    // R9: hardware-only flags
    cpu_write(3'd0, 16'h00C0);
    stat_bit("R9", 7, 0);
    @(posedge clk); #1 nack_strobe = 1;
    @(posedge clk); #1 nack_strobe = 0;
    stat_bit("R9", 7, 1);
    cpu_write(3'd0, 16'h0080);
    stat_bit("R9", 7, 1);
    cpu_write(3'd0, 16'h0000);
    stat_bit("R9", 7, 0);
    cpu_write(3'd2, 16'h0003);
    chk("R9", {15'h0, master_mode}, 16'h1);
    @(posedge clk); #1 arb_lost_strobe = 1;
    @(posedge clk); #1 arb_lost_strobe = 0;
    chk("R9", {15'h0, master_mode}, 16'h0);
    stat_bit("R9", 6, 1);

    // R11: mask
    cpu_write(3'd3, 16'h0000);
    chk("R11", {15'h0, irq}, 16'h0);
    cpu_write(3'd3, 16'h0040);
    chk("R11", {15'h0, irq}, 16'h1);
    cpu_write(3'd0, 16'h0000);

    // R12: transmit byte
    cpu_write(3'd1, 16'h01AB);
    chk("R12", {8'h0, tx_byte}, 16'h00AB);
    chk("R12", {9'h0, tx_addr}, 16'h002B);
    cpu_read(3'd1, r);
    chk("R12", r, 16'h0044);

    // R2: disable while busy
    lines(1, 0);
    stat_bit("R2", 15, 1);
    cpu_write(3'd2, 16'h0000);
    stat_bit("R2", 15, 0);
    lines(1, 1);
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule